// File: doc/BRIEF.md
# Synchronised Graph-Node Lock Store

This block keeps one status word per graph node inside a memory unit: an evaluated flag, a lock bit and the head of a list of suspended requesters. A processor that wants to reduce a node fetches it. The first fetch of an unevaluated node claims it by setting the lock. A fetch of a node that is already in normal form always succeeds, and it never locks, because that node can never change again. A fetch of a node that is claimed is refused. The requester's task descriptor is then linked onto that node's waiter list in a shared descriptor memory, so the caller has no follow-up work to do.

When the owning task writes the result back with an update, the node becomes evaluated and its lock clears. The store then walks the waiter list by itself and releases one descriptor per cycle. A descriptor goes to the task-pool port, or to the processor-notification port when the waiter asked to be woken on the processor that holds it. While a list is being drained the request port is closed. A combinational status port lets the task pool tell whether a sparked node is already claimed or evaluated, so that it can drop orphan sparks.

Top module: `node_lock_store`

## Requirements
- R1: After reset, every node reads unevaluated and unlocked on the status port, `req_ready` is 1, and `rsp_valid`, `pool_valid` and `ntf_valid` are 0.
- R2: An accepted fetch (`req_upd`=0) of an unevaluated, unlocked node answers with `rsp_code` 1 (claimed) in the next cycle, and the node then reads locked.
- R3: An accepted fetch of a locked node answers with `rsp_code` 3 (suspended) when a descriptor slot is free, and it attaches `req_task` and `req_notify` to that node.
- R4: An accepted fetch of an evaluated node answers with `rsp_code` 2 (value ready) and leaves the node's status unchanged.
- R5: An accepted update (`req_upd`=1) of a locked, unevaluated node answers with `rsp_code` 5 (done), and the node then reads evaluated and unlocked.
- R6: An update of a node that is unlocked or already evaluated answers with `rsp_code` 6 (protocol error) and leaves the node's status unchanged.
- R7: After a successful update, the attached waiters are released one per handshake in newest-first order. A waiter with notify flag 0 is released on the pool port and one with notify flag 1 on the notify port. A valid output holds its data stable until it is accepted, and the two ports are never valid in the same cycle.
- R8: `req_ready` is 0 from the cycle after a successful update that has waiters until the cycle after the last waiter is accepted. No request is taken while it is 0.
- R9: An accepted fetch of a locked node while all descriptor slots are in use answers with `rsp_code` 4 (retry) and attaches nothing. Slots freed by a drain can be used again.
- R10: The status port reports `qry_evaluated` and `qry_locked` for `qry_node` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_upd | input | 1 | 0 = fetch, 1 = update with evaluated form |
| req_node | input | NW | Node index |
| req_task | input | TW | Descriptor of the requesting task |
| req_notify | input | 1 | Wake the waiter via the notify port instead of the pool |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_code | output | 3 | 1 claimed, 2 value ready, 3 suspended, 4 retry, 5 done, 6 protocol error |
| qry_node | input | NW | Node index for the status lookup |
| qry_evaluated | output | 1 | Queried node is in normal form |
| qry_locked | output | 1 | Queried node is claimed |
| pool_valid | output | 1 | Released descriptor for the task pool |
| pool_ready | input | 1 | Task pool accepts the descriptor |
| pool_task | output | TW | Released descriptor |
| ntf_valid | output | 1 | Released descriptor for processor notification |
| ntf_ready | input | 1 | Notification path accepts |
| ntf_task | output | TW | Released descriptor |

## Verification
A corrupt waiter chain or free list shows up at the ports within a few cycles of the next update. The release order on the pool and notify ports breaks, a descriptor appears twice or goes missing, or `req_ready` stays low. A lost free slot shows up as a retry code on a later suspended fetch, while the same fetch on a correct design would be suspended. A wrong lock or evaluated bit shows up in the very next response code and on the status port.

// File: rtl/nls_pkg.sv
package nls_pkg;
  typedef enum logic [2:0] {
    RSP_NONE    = 3'd0,
    RSP_CLAIMED = 3'd1,
    RSP_READY   = 3'd2,
    RSP_SUSPEND = 3'd3,
    RSP_RETRY   = 3'd4,
    RSP_DONE    = 3'd5,
    RSP_PERR    = 3'd6
  } rsp_e;
endpackage

// File: rtl/nls_node_table.sv
module nls_node_table #(
  parameter int NODES = 16,
  parameter int NW    = 4,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] rd_node,
  output logic          rd_eval,
  output logic          rd_lock,
  output logic [DW-1:0] rd_head,
  output logic          rd_hvld,
  input  logic [NW-1:0] q_node,
  output logic          q_eval,
  output logic          q_lock,
  input  logic          we,
  input  logic [NW-1:0] wr_node,
  input  logic          wr_eval,
  input  logic          wr_lock,
  input  logic [DW-1:0] wr_head,
  input  logic          wr_hvld
);
  logic          ev_q   [NODES];
  logic          lk_q   [NODES];
  logic [DW-1:0] hd_q   [NODES];
  logic          hv_q   [NODES];

  for (genvar g = 0; g < NODES; g++) begin : g_node
    logic sel;
    assign sel = we && (wr_node == NW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_q[g] <= 1'b0;
        lk_q[g] <= 1'b0;
        hd_q[g] <= '0;
        hv_q[g] <= 1'b0;
      end else if (sel) begin
        ev_q[g] <= wr_eval;
        lk_q[g] <= wr_lock;
        hd_q[g] <= wr_head;
        hv_q[g] <= wr_hvld;
      end
    end
  end

  assign rd_eval = ev_q[rd_node];
  assign rd_lock = lk_q[rd_node];
  assign rd_head = hd_q[rd_node];
  assign rd_hvld = hv_q[rd_node];
  assign q_eval  = ev_q[q_node];
  assign q_lock  = lk_q[q_node];
endmodule

// File: rtl/nls_waiter_mem.sv
module nls_waiter_mem #(
  parameter int DESC = 4,
  parameter int TW   = 8,
  parameter int DW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [TW-1:0] a_task,
  input  logic          a_ntf,
  input  logic [DW-1:0] a_next,
  input  logic          a_next_vld,
  output logic          free_vld,
  output logic [DW-1:0] free_idx,
  input  logic          rel,
  input  logic [DW-1:0] rel_idx,
  input  logic [DW-1:0] rd_idx,
  output logic [TW-1:0] rd_task,
  output logic          rd_ntf,
  output logic [DW-1:0] rd_next,
  output logic          rd_next_vld
);
  logic [TW-1:0] tk_q [DESC];
  logic          nf_q [DESC];
  logic [DW-1:0] nx_q [DESC];
  logic          nv_q [DESC];
  logic [DW-1:0] fh_q;
  logic          fv_q;

  // one chain pointer per slot, shared by the free list and the waiter lists
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC; i++) begin
        nx_q[i] <= DW'(i + 1);
        nv_q[i] <= (i != DESC - 1);
      end
      fh_q <= '0;
      fv_q <= 1'b1;
    end else if (alloc) begin
      nx_q[fh_q] <= a_next;
      nv_q[fh_q] <= a_next_vld;
      fh_q       <= nx_q[fh_q];
      fv_q       <= nv_q[fh_q];
    end else if (rel) begin
      nx_q[rel_idx] <= fh_q;
      nv_q[rel_idx] <= fv_q;
      fh_q          <= rel_idx;
      fv_q          <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      tk_q[fh_q] <= a_task;
      nf_q[fh_q] <= a_ntf;
    end
  end

  assign free_vld    = fv_q;
  assign free_idx    = fh_q;
  assign rd_task     = tk_q[rd_idx];
  assign rd_ntf      = nf_q[rd_idx];
  assign rd_next     = nx_q[rd_idx];
  assign rd_next_vld = nv_q[rd_idx];
endmodule

// File: rtl/node_lock_store.sv
module node_lock_store #(
  parameter int NODES = 16,
  parameter int DESC  = 4,
  parameter int TW    = 8,
  parameter int NW    = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_upd,
  input  logic [NW-1:0] req_node,
  input  logic [TW-1:0] req_task,
  input  logic          req_notify,
  output logic          rsp_valid,
  output logic [2:0]    rsp_code,
  input  logic [NW-1:0] qry_node,
  output logic          qry_evaluated,
  output logic          qry_locked,
  output logic          pool_valid,
  input  logic          pool_ready,
  output logic [TW-1:0] pool_task,
  output logic          ntf_valid,
  input  logic          ntf_ready,
  output logic [TW-1:0] ntf_task
);
  import nls_pkg::*;
  localparam int DW = (DESC > 1) ? $clog2(DESC) : 1;

  logic          n_eval, n_lock, n_hvld;
  logic [DW-1:0] n_head;
  logic          tbl_we, wr_eval, wr_lock, wr_hvld;
  logic [DW-1:0] wr_head;
  logic          alloc, rel, free_vld;
  logic [DW-1:0] free_idx;
  logic [TW-1:0] w_task;
  logic          w_ntf, w_next_vld;
  logic [DW-1:0] w_next;

  logic          drain_q, drain_d;
  logic [DW-1:0] cur_q, cur_d;
  logic          rv_q, rv_d;
  rsp_e          rc_q, rc_d;
  logic          accept, fire;

  nls_node_table #(.NODES(NODES), .NW(NW), .DW(DW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_node(req_node), .rd_eval(n_eval), .rd_lock(n_lock),
    .rd_head(n_head), .rd_hvld(n_hvld),
    .q_node(qry_node), .q_eval(qry_evaluated), .q_lock(qry_locked),
    .we(tbl_we), .wr_node(req_node), .wr_eval(wr_eval), .wr_lock(wr_lock),
    .wr_head(wr_head), .wr_hvld(wr_hvld)
  );

  nls_waiter_mem #(.DESC(DESC), .TW(TW), .DW(DW)) u_wmem (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc), .a_task(req_task), .a_ntf(req_notify),
    .a_next(n_head), .a_next_vld(n_hvld),
    .free_vld(free_vld), .free_idx(free_idx),
    .rel(rel), .rel_idx(cur_q),
    .rd_idx(cur_q), .rd_task(w_task), .rd_ntf(w_ntf),
    .rd_next(w_next), .rd_next_vld(w_next_vld)
  );

  assign req_ready  = !drain_q;
  assign accept     = req_valid && !drain_q;
  assign pool_valid = drain_q && !w_ntf;
  assign ntf_valid  = drain_q && w_ntf;
  assign pool_task  = w_task;
  assign ntf_task   = w_task;
  assign fire       = (pool_valid && pool_ready) || (ntf_valid && ntf_ready);

  always_comb begin
    tbl_we  = 1'b0;
    wr_eval = n_eval;
    wr_lock = n_lock;
    wr_head = n_head;
    wr_hvld = n_hvld;
    alloc   = 1'b0;
    rel     = 1'b0;
    drain_d = drain_q;
    cur_d   = cur_q;
    rv_d    = accept;
    rc_d    = RSP_NONE;
    if (accept && !req_upd) begin
      if (n_eval) begin
        rc_d = RSP_READY;
      end else if (!n_lock) begin
        tbl_we  = 1'b1;
        wr_lock = 1'b1;
        rc_d    = RSP_CLAIMED;
      end else if (free_vld) begin
        tbl_we  = 1'b1;
        alloc   = 1'b1;
        wr_head = free_idx;
        wr_hvld = 1'b1;
        rc_d    = RSP_SUSPEND;
      end else begin
        rc_d = RSP_RETRY;
      end
    end else if (accept) begin
      if (!n_lock || n_eval) begin
        rc_d = RSP_PERR;
      end else begin
        tbl_we  = 1'b1;
        wr_eval = 1'b1;
        wr_lock = 1'b0;
        wr_hvld = 1'b0;
        rc_d    = RSP_DONE;
        if (n_hvld) begin
          drain_d = 1'b1;
          cur_d   = n_head;
        end
      end
    end
    if (fire) begin
      rel = 1'b1;
      if (w_next_vld) cur_d = w_next;
      else            drain_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      cur_q   <= '0;
      rv_q    <= 1'b0;
      rc_q    <= RSP_NONE;
    end else begin
      drain_q <= drain_d;
      cur_q   <= cur_d;
      rv_q    <= rv_d;
      rc_q    <= rc_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_code  = rc_q;
endmodule

// File: rtl/nls_checker.sv
module nls_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_upd,
  input logic          n_eval,
  input logic          n_lock,
  input logic          free_vld,
  input logic          rsp_valid,
  input logic [2:0]    rsp_code,
  input logic          pool_valid,
  input logic          pool_ready,
  input logic [TW-1:0] pool_task,
  input logic          ntf_valid,
  input logic          ntf_ready,
  input logic [TW-1:0] ntf_task
);
  logic acc_f, acc_u;
  assign acc_f = req_valid && req_ready && !req_upd;
  assign acc_u = req_valid && req_ready && req_upd;

  a_r2_claim: assert property (@(posedge clk) disable iff (!rst_n)
    acc_f && !n_eval && !n_lock |=> rsp_valid && rsp_code == 3'd1);
  a_r3_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    acc_f && n_lock && free_vld |=> rsp_valid && rsp_code == 3'd3);
  a_r4_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_f && n_eval |=> rsp_valid && rsp_code == 3'd2);
  a_r6_perr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_u && (!n_lock || n_eval) |=> rsp_valid && rsp_code == 3'd6);
  a_r9_retry: assert property (@(posedge clk) disable iff (!rst_n)
    acc_f && n_lock && !free_vld |=> rsp_valid && rsp_code == 3'd4);
  a_r7_pool_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pool_valid && !pool_ready |=> pool_valid && $stable(pool_task));
  a_r7_ntf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_task));
  a_r7_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(pool_valid && ntf_valid));
  a_r8_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_valid || ntf_valid) |-> !req_ready);
endmodule

bind node_lock_store nls_checker #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_upd(req_upd), .n_eval(n_eval), .n_lock(n_lock), .free_vld(free_vld),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .pool_valid(pool_valid), .pool_ready(pool_ready), .pool_task(pool_task),
  .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_task(ntf_task)
);

// File: tb/sim_node_lock_store.sv
module sim_node_lock_store;
  logic       clk, rst_n;
  logic       req_valid, req_ready, req_upd, req_notify;
  logic [3:0] req_node, qry_node;
  logic [7:0] req_task, pool_task, ntf_task;
  logic       rsp_valid, qry_evaluated, qry_locked;
  logic [2:0] rsp_code;
  logic       pool_valid, pool_ready, ntf_valid, ntf_ready;
  int checks = 0, errors = 0, cycles = 0;

  node_lock_store #(.NODES(16), .DESC(4), .TW(8)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {update, node[3:0], expected code[2:0]}
  localparam logic [7:0] VEC [13] = '{
    {1'b0, 4'd3,  3'd1}, {1'b0, 4'd5,  3'd1}, {1'b1, 4'd3,  3'd5},
    {1'b0, 4'd3,  3'd2}, {1'b1, 4'd3,  3'd6}, {1'b1, 4'd7,  3'd6},
    {1'b0, 4'd7,  3'd1}, {1'b1, 4'd5,  3'd5}, {1'b1, 4'd7,  3'd5},
    {1'b0, 4'd0,  3'd1}, {1'b0, 4'd15, 3'd1}, {1'b1, 4'd15, 3'd5},
    {1'b0, 4'd15, 3'd2}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input logic upd, input logic [3:0] nd, input logic [7:0] tk,
                    input logic nt, input logic [2:0] exp, input string req);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_upd = upd; req_node = nd; req_task = tk; req_notify = nt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_code == exp, req, {rsp_valid, rsp_code}, {1'b1, exp});
  endtask

  task automatic status(input logic [3:0] nd, input logic ev, input logic lk, input string req);
    qry_node = nd;
    #1;
    chk(qry_evaluated == ev && qry_locked == lk, req,
        {qry_evaluated, qry_locked}, {ev, lk});
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_upd = 1'b0; req_node = '0; req_task = '0;
    req_notify = 1'b0; qry_node = '0; pool_ready = 1'b0; ntf_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !pool_valid && !ntf_valid, "R1",
        {req_ready, rsp_valid, pool_valid, ntf_valid}, 4'b1000);
    status(4'd9, 1'b0, 1'b0, "R1 R10");

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < 13; i++)
      op(VEC[i][7], VEC[i][6:3], 8'h00, 1'b0, VEC[i][2:0], "R2/R4/R5/R6 vector");
    status(4'd3, 1'b1, 1'b0, "R5 R10");
    status(4'd0, 1'b0, 1'b1, "R2 R10");
    status(4'd7, 1'b1, 1'b0, "R6 node 7 after errors");

    // R3 suspend four waiters on node 0; R9 retry on the fifth
    op(1'b0, 4'd0, 8'hA1, 1'b0, 3'd3, "R3");
    op(1'b0, 4'd0, 8'hA2, 1'b1, 3'd3, "R3");
    op(1'b0, 4'd0, 8'hA3, 1'b0, 3'd3, "R3");
    op(1'b0, 4'd0, 8'hA4, 1'b0, 3'd3, "R3");
    op(1'b0, 4'd0, 8'hA5, 1'b0, 3'd4, "R9 retry");
    op(1'b0, 4'd9, 8'h00, 1'b0, 3'd1, "R2 claim while slots full");
    status(4'd0, 1'b0, 1'b1, "R3 still locked");

    // R7 R8 drain newest first, held while not ready
    op(1'b1, 4'd0, 8'h00, 1'b0, 3'd5, "R5 update with waiters");
    chk(pool_valid && pool_task == 8'hA4, "R7 first", pool_task, 8'hA4);
    chk(!req_ready, "R8 closed", req_ready, 0);
    @(negedge clk);
    chk(pool_valid && pool_task == 8'hA4 && !ntf_valid, "R7 hold", pool_task, 8'hA4);
    pool_ready = 1'b1; ntf_ready = 1'b1;
    @(negedge clk);
    chk(pool_valid && pool_task == 8'hA3, "R7 second", pool_task, 8'hA3);
    @(negedge clk);
    chk(ntf_valid && !pool_valid && ntf_task == 8'hA2, "R7 notify", ntf_task, 8'hA2);
    chk(!req_ready, "R8 closed mid", req_ready, 0);
    @(negedge clk);
    chk(pool_valid && pool_task == 8'hA1, "R7 last", pool_task, 8'hA1);
    @(negedge clk);
    chk(!pool_valid && !ntf_valid && req_ready, "R8 reopened",
        {pool_valid, ntf_valid, req_ready}, 3'b001);
    status(4'd0, 1'b1, 1'b0, "R5 R10 node 0");

    // R9 slots reusable after drain
    op(1'b0, 4'd9, 8'hB1, 1'b1, 3'd3, "R9 reuse");
    op(1'b1, 4'd9, 8'h00, 1'b0, 3'd5, "R5 node 9");
    chk(ntf_valid && ntf_task == 8'hB1, "R7 single notify", ntf_task, 8'hB1);
    @(negedge clk);
    chk(!ntf_valid && req_ready, "R8 single", {ntf_valid, req_ready}, 2'b01);
    op(1'b0, 4'd9, 8'h00, 1'b0, 3'd2, "R4 after drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule